// File: doc/BRIEF.md
# Receive Packet Admission Gate

This block sits between the receive side of a 256-bit Ethernet MAC and the write port of a 512-entry receive FIFO. Beats arrive in a valid/end-of-packet stream. On the first valid beat of each packet the block looks at the FIFO's write-side fill count. If enough room is left for a jumbo frame of about 9 KB, the whole packet is written beat by beat. If not, the whole packet is discarded up to and including its last beat. A packet is therefore never written partly.

Every write reaches the FIFO one clock after the beat was seen on the input. The data word, the end-of-packet flag and the residual-byte field all travel with the registered write strobe. A wrapping counter records how many packets have been discarded. The block runs entirely in the receive clock domain.

Top module: `rx_pkt_admit`

## Requirements
- R1: During and straight after synchronous active-low reset, `fifo_wr_en` is 0 and `drop_count` is 0.
- R2: A packet whose first valid beat sees `fifo_fill` below 224 is admitted. Each of its valid beats, including the first and the one with `mac_eop`=1, produces exactly one write.
- R3: A packet whose first valid beat sees `fifo_fill` of 224 or more is flushed. No beat of it is written, up to and including the beat where `mac_valid`=1 and `mac_eop`=1. A fill of exactly 224 flushes and 223 admits.
- R4: While a packet is being admitted, a cycle with `mac_valid`=0 produces no write one cycle later, and the packet then continues.
- R5: A write in cycle t+1 carries `mac_data`, `mac_eop` and `mac_empty` as they were in cycle t.
- R6: After a beat with `mac_valid`=1 and `mac_eop`=1, whether the packet was admitted or flushed, the next valid beat starts a new packet with a fresh decision.
- R7: Changes of `fifo_fill` after the first beat of a packet do not alter the admit or flush decision for that packet.
- R8: `drop_count` increases by exactly one for every flushed packet, in the cycle after the packet's first beat, and does not change otherwise.
- R9: A one-beat packet (first beat has `mac_eop`=1) is written once if admitted, or counted once as dropped. The next valid beat is again a packet start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mac_valid | input | 1 | Beat valid from the MAC |
| mac_data | input | 256 | Beat data |
| mac_eop | input | 1 | Last beat of the packet |
| mac_empty | input | 5 | Unused byte count in the last beat |
| fifo_fill | input | 9 | Write-side fill count of the receive FIFO |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 256 | FIFO write data |
| fifo_wr_eop | output | 1 | End-of-packet bit stored with the data |
| fifo_wr_empty | output | 5 | Residual-byte field stored with the data |
| drop_count | output | 16 | Count of flushed packets, wrapping |

## Verification
The hardest case to reach is a fill count that moves across the 224 threshold in the middle of a packet. Only the first-beat sample may count, so a design that checks the fill again on a later beat looks correct for most traffic. The stimulus produces this case in two ways. Directed packets start at 223 and at 224 and then jump to the opposite side on later beats. The random packets also draw a new fill value on every beat, weighted around the threshold, and insert idle gaps inside the packets.

// File: rtl/rx_admit_pkg.sv
// Shared types for the receive admission gate.
package rx_admit_pkg;
    // Packet-level state of the admission machine.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_DRAIN = 2'd2
    } adm_state_t;
endpackage

// File: rtl/rx_admit_fsm.sv
// Admission machine: decides once per packet, on its first valid beat,
// whether the packet is stored or drained. Assumes the fill count is
// the FIFO write-side count, valid in the same cycle as the beat.
module rx_admit_fsm
    import rx_admit_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int ADMIT_LIMIT = 224
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_vld,
    input  logic             beat_last,
    input  logic [CNT_W-1:0] fill,
    output logic             store_beat,
    output logic             drop_pulse,
    output adm_state_t       state
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ADMIT_LIMIT);

    logic       room_ok;
    adm_state_t state_nx;

    assign room_ok = (fill < LIMIT);

    // Beat goes to the FIFO when it opens an admitted packet or continues one.
    always_comb begin
        store_beat = 1'b0;
        drop_pulse = 1'b0;
        if (beat_vld) begin
            case (state)
                ST_IDLE:  begin
                    store_beat = room_ok;
                    drop_pulse = !room_ok;
                end
                ST_STORE: store_beat = 1'b1;
                default:  store_beat = 1'b0;
            endcase
        end
    end

    // Next-state selection; a last beat always ends in idle.
    always_comb begin
        state_nx = state;
        if (beat_vld) begin
            case (state)
                ST_IDLE: begin
                    if (!beat_last) state_nx = room_ok ? ST_STORE : ST_DRAIN;
                end
                default: begin
                    if (beat_last) state_nx = ST_IDLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Draining persists until a valid last beat (R3).
    assert_drain_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !(beat_vld && beat_last)) |=> state == ST_DRAIN);

    // Any valid last beat returns the machine to idle (R6).
    assert_last_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && beat_last) |=> state == ST_IDLE);

    // Storing and dropping never both happen for a beat (R2, R3).
    assert_store_xor_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_beat && drop_pulse));
endmodule

// File: rtl/rx_beat_pipe.sv
// One-stage register between the MAC beat and the FIFO write port.
// Data, end flag and residual field are captured every cycle; the write
// strobe is the registered store decision, so all stay aligned.
module rx_beat_pipe #(
    parameter int DATA_W  = 256,
    parameter int EMPTY_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_last,
    input  logic [EMPTY_W-1:0] in_empty,
    output logic               wr_en,
    output logic [DATA_W-1:0]  wr_data,
    output logic               wr_last,
    output logic [EMPTY_W-1:0] wr_empty
);
    // Delay every field by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            wr_data  <= '0;
            wr_last  <= 1'b0;
            wr_empty <= '0;
        end else begin
            wr_en    <= wr_req;
            wr_data  <= in_data;
            wr_last  <= in_last;
            wr_empty <= in_empty;
        end
    end
endmodule

// File: rtl/rx_drop_counter.sv
// Wrapping count of discarded packets; one pulse per packet expected.
module rx_drop_counter #(
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bump,
    output logic [DROP_W-1:0] count
);
    localparam logic [DROP_W-1:0] ONE = DROP_W'(1);

    // Increment on each drop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (bump) count <= count + ONE;
    end
endmodule

// File: rtl/rx_pkt_admit.sv
// Top of the receive admission gate. Assumes the MAC marks the last
// beat of each packet with eop and that fifo_fill is the FIFO's own
// write-side count. Packets are admitted or dropped whole.
module rx_pkt_admit
    import rx_admit_pkg::*;
#(
    parameter int DATA_W      = 256,
    parameter int EMPTY_W     = 5,
    parameter int FIFO_DEPTH  = 512,
    parameter int ADMIT_LIMIT = 224,
    parameter int DROP_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mac_valid,
    input  logic [DATA_W-1:0]             mac_data,
    input  logic                          mac_eop,
    input  logic [EMPTY_W-1:0]            mac_empty,
    input  logic [$clog2(FIFO_DEPTH)-1:0] fifo_fill,
    output logic                          fifo_wr_en,
    output logic [DATA_W-1:0]             fifo_wr_data,
    output logic                          fifo_wr_eop,
    output logic [EMPTY_W-1:0]            fifo_wr_empty,
    output logic [DROP_W-1:0]             drop_count
);
    localparam int CNT_W = $clog2(FIFO_DEPTH);

    logic       store_beat;
    logic       drop_pulse;
    adm_state_t state;

    rx_admit_fsm #(.CNT_W(CNT_W), .ADMIT_LIMIT(ADMIT_LIMIT)) fsm_i (
        .clk(clk), .rst_n(rst_n), .beat_vld(mac_valid), .beat_last(mac_eop),
        .fill(fifo_fill), .store_beat(store_beat), .drop_pulse(drop_pulse),
        .state(state)
    );

    rx_beat_pipe #(.DATA_W(DATA_W), .EMPTY_W(EMPTY_W)) pipe_i (
        .clk(clk), .rst_n(rst_n), .wr_req(store_beat), .in_data(mac_data),
        .in_last(mac_eop), .in_empty(mac_empty), .wr_en(fifo_wr_en),
        .wr_data(fifo_wr_data), .wr_last(fifo_wr_eop), .wr_empty(fifo_wr_empty)
    );

    rx_drop_counter #(.DROP_W(DROP_W)) drops_i (
        .clk(clk), .rst_n(rst_n), .bump(drop_pulse), .count(drop_count)
    );

    // Write carries the previous cycle's beat fields (R5).
    assert_wr_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> (fifo_wr_data == $past(mac_data) &&
                        fifo_wr_eop == $past(mac_eop) &&
                        fifo_wr_empty == $past(mac_empty)));

    // No write without a valid beat one cycle before (R4).
    assert_no_write_on_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_valid |=> !fifo_wr_en);

    // Valid beat inside a stored packet is always written (R2).
    assert_store_continues_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && mac_valid) |=> fifo_wr_en);

    // Draining state never produces a write (R3).
    assert_drain_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> !fifo_wr_en);

    // Drop count moves by at most one per cycle (R8).
    assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (drop_count == $past(drop_count) ||
                          drop_count == $past(drop_count) + DROP_W'(1)));
endmodule

// File: tb/rx_pkt_admit_tb.sv
module rx_pkt_admit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 224;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mac_valid = 1'b0;
    logic [255:0] mac_data = '0;
    logic         mac_eop = 1'b0;
    logic [4:0]   mac_empty = '0;
    logic [8:0]   fifo_fill = '0;
    logic         fifo_wr_en;
    logic [255:0] fifo_wr_data;
    logic         fifo_wr_eop;
    logic [4:0]   fifo_wr_empty;
    logic [15:0]  drop_count;

    int n_checks = 0;
    int n_fail   = 0;
    int m_state  = 0;   // 0 idle, 1 storing, 2 draining
    logic [15:0] m_drops = '0;
    bit finished = 0;

    rx_pkt_admit dut_i (
        .clk(clk), .rst_n(rst_n), .mac_valid(mac_valid), .mac_data(mac_data),
        .mac_eop(mac_eop), .mac_empty(mac_empty), .fifo_fill(fifo_fill),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .fifo_wr_eop(fifo_wr_eop), .fifo_wr_empty(fifo_wr_empty),
        .drop_count(drop_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [255:0] rnd256();
        return {$urandom(), $urandom(), $urandom(), $urandom(),
                $urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // Fill value weighted around the admission threshold.
    function automatic logic [8:0] rnd_fill();
        int r = $urandom_range(0, 3);
        if (r == 0) return 9'($urandom_range(LIMIT - 3, LIMIT + 2));
        return 9'($urandom_range(0, 511));
    endfunction

    task automatic check(input string req, input bit ok, input logic [255:0] act,
                         input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle, model it from the requirements, check after the edge.
    task automatic beat(input bit v, input bit e, input logic [8:0] f,
                        input string tag);
        logic [255:0] d;
        logic [4:0]   em;
        bit           exp_wr;
        d  = rnd256();
        em = 5'($urandom_range(0, 31));
        @(negedge clk);
        mac_valid = v; mac_eop = e; mac_data = d; mac_empty = em; fifo_fill = f;
        exp_wr = v && ((m_state == 0 && f < LIMIT) || m_state == 1);
        if (v) begin
            if (m_state == 0) begin
                if (f >= LIMIT) m_drops++;
                if (!e) m_state = (f < LIMIT) ? 1 : 2;
            end else if (e) m_state = 0;
        end
        @(posedge clk); #1;
        check(tag, fifo_wr_en == exp_wr, 256'(fifo_wr_en), 256'(exp_wr));
        if (exp_wr && fifo_wr_en) begin
            check("R5 data", fifo_wr_data == d, fifo_wr_data, d);
            check("R5 eop/empty", fifo_wr_eop == e && fifo_wr_empty == em,
                  256'({fifo_wr_eop, fifo_wr_empty}), 256'({e, em}));
        end
        check("R8 drop_count", drop_count == m_drops, 256'(drop_count), 256'(m_drops));
    endtask

    task automatic packet(input int len, input logic [8:0] first_fill,
                          input logic [8:0] later_fill, input bit gaps, input string tag);
        for (int i = 0; i < len; i++) begin
            if (gaps && i > 0 && $urandom_range(0, 2) == 0)
                beat(1'b0, 1'b0, later_fill, "R4 gap");
            beat(1'b1, i == len - 1, (i == 0) ? first_fill : later_fill, tag);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk); #1;
        check("R1 wr_en in reset", fifo_wr_en == 1'b0, 256'(fifo_wr_en), 0);
        check("R1 drops in reset", drop_count == 16'd0, 256'(drop_count), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 wr_en after reset", fifo_wr_en == 1'b0, 256'(fifo_wr_en), 0);

        // Directed boundary cases.
        packet(4, 9'd223, 9'd223, 0, "R2 fill 223 admits");
        packet(4, 9'd224, 9'd224, 0, "R3 fill 224 flushes");
        packet(5, 9'd223, 9'd400, 0, "R7 fill rises mid-packet");
        packet(5, 9'd224, 9'd0,   0, "R7 fill falls mid-packet");
        packet(1, 9'd10,  9'd10,  0, "R9 single beat admitted");
        packet(1, 9'd300, 9'd300, 0, "R9 single beat dropped");
        packet(3, 9'd511, 9'd0,   1, "R3 full fifo with gaps");
        packet(3, 9'd0,   9'd511, 1, "R6 new decision after flush");
        packet(6, 9'd100, 9'd100, 1, "R4 admitted with gaps");

        // Random traffic.
        for (int p = 0; p < 400; p++) begin
            int len = $urandom_range(1, 6);
            for (int i = 0; i < len; i++) begin
                if (i > 0 && $urandom_range(0, 3) == 0)
                    beat(1'b0, 1'b0, rnd_fill(), "R4 random gap");
                beat(1'b1, i == len - 1, rnd_fill(), "R2/R3 random R6");
            end
            if ($urandom_range(0, 2) == 0) beat(1'b0, 1'b0, rnd_fill(), "R6 idle");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule